// File: doc/BRIEF.md
# DSD Bitstream Validity Monitor

This block sits on a one-bit DSD audio stream and checks each accepted bit for two kinds of faulty content. A static stream is a long run of identical bits. When the run reaches 28 bits the block raises a mute request, and it drops that request on the first bit that differs. An invalid stream is a 28-bit window in which one value takes more than 24 positions. When the block sees one, it raises an attenuate request and replaces the forwarded bits with a DSD silence pattern that alternates 0 and 1.

A small configuration register holds five fields: the enable for each detector, a direct-conversion bypass, and two phase-modulation clocking fields. The register loads on a strobe and returns to its defaults on reset. In bypass the stream is forwarded untouched, because no attenuation exists on that path. Both detectors still report in bypass. The phase-modulation fields only tell the downstream clocking whether the serial clock is the 64x rate rather than the default 128x rate.

Top module: `dsd_stream_monitor`

## Requirements
- R1: When the static detector is enabled, `mute_req` is 1 from the clock edge that accepts the 28th consecutive identical valid bit. It stays 1 while further identical bits arrive.
- R2: `mute_req` returns to 0 at the clock edge that accepts the first valid bit that differs from the previous one. The run count restarts at 1 with that bit.
- R3: After reset the static detector is enabled. While its enable is 0, `mute_req` is 0 from the next clock edge, whatever the run length. The run is still counted, so re-enabling during a long run raises `mute_req` again.
- R4: When the invalid detector is enabled, `atten_req` is 1 after an edge at which at least 28 valid bits have been accepted since reset and the last 28 bits contain more than 24 ones or fewer than 4 ones. Otherwise it is 0. The request is re-evaluated on every clock from the current state and configuration.
- R5: After reset the invalid detector is disabled, so `atten_req` stays 0 for any stream until the enable is loaded.
- R6: Each valid bit appears on `dout` one clock later, with `dout_valid` 1 for exactly that clock. If that same bit makes the attenuate condition true while bypass is 0, `dout` instead carries the idle phase. The idle phase is 0 after reset and inverts on every accepted bit, so gated stretches show an alternating 0/1 pattern.
- R7: With bypass set (reset value 0), `dout` always equals the accepted bit. `atten_req` is still reported.
- R8: `pm_sclk_64x` is 1 only when both the phase-modulation enable and the 64x rate select are 1. Both fields reset to 0, which selects the 128x clock with the mode off.
- R9: Configuration fields are captured only at an edge where `cfg_load` is 1. Field values presented while `cfg_load` is 0 have no effect.
- R10: Synchronous reset clears the bit history, the run count, the fill count, both requests, `dout`, `dout_valid` and the idle phase. Detection then needs 28 new bits.
- R11: A clock with `bit_valid` at 0 leaves the history, the counts and `dout` unchanged and gives `dout_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DSD bit clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Incoming DSD bit |
| bit_valid | input | 1 | Qualifies `bit_in` on this clock |
| cfg_load | input | 1 | Captures the five configuration fields |
| cfg_static_en | input | 1 | Static (run) detector enable, reset 1 |
| cfg_invalid_en | input | 1 | Invalid (dominance) detector enable, reset 0 |
| cfg_bypass | input | 1 | Direct-conversion bypass, reset 0 |
| cfg_pm_en | input | 1 | Phase-modulation input enable, reset 0 |
| cfg_pm_rate64 | input | 1 | 1 selects 64x serial clock, 0 selects 128x, reset 0 |
| mute_req | output | 1 | Static stream detected |
| atten_req | output | 1 | Invalid stream detected |
| dout | output | 1 | Forwarded or gated DSD bit |
| dout_valid | output | 1 | Qualifies `dout` |
| pm_sclk_64x | output | 1 | Phase-modulation mode active with the 64x clock |

## Verification
The hardest cases to reach are the dominance thresholds on either side of the decision: 24 against 25 ones, and 3 against 4 ones. These have to be hit at the exact bit where the window first becomes full, and again as the window slides. The bench covers them by sweeping the number of ones per 28-bit window from 0 to 28. In each pattern the ones are spread evenly, and each pattern follows a fresh reset. For every count the bench checks the first full window and 28 further sliding positions against a model that counts the ones again from its own bit history. Run lengths just below and above 28, mid-run enable changes, gaps in the valid strobe and a mid-stream reset are added separately.

// File: rtl/dsd_mon_pkg.sv
package dsd_mon_pkg;

  typedef struct packed {
    logic static_en;
    logic invalid_en;
    logic bypass;
    logic pm_en;
    logic pm_rate64;
  } mon_cfg_t;

  localparam mon_cfg_t CFG_DEFAULT = '{static_en: 1'b1, invalid_en: 1'b0,
                                       bypass: 1'b0, pm_en: 1'b0, pm_rate64: 1'b0};

  // One value takes more than lim of win positions.
  function automatic logic is_dominant(input int unsigned ones,
                                       input int unsigned win,
                                       input int unsigned lim);
    return (ones > lim) || (ones + lim < win);
  endfunction

  // Next run length: restart on change or first bit, saturate at cap.
  function automatic int unsigned next_run(input int unsigned run,
                                           input logic same,
                                           input int unsigned cap);
    if (!same) return 1;
    if (run < cap) return run + 1;
    return cap;
  endfunction

endpackage

// File: rtl/dsd_run_detector.sv
module dsd_run_detector #(
  parameter int unsigned RUN_LEN = 28,
  localparam int unsigned CW = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_valid,
  input  logic enable,
  output logic mute_req,
  output logic prev_bit,
  output logic have_prev
);
  import dsd_mon_pkg::*;

  logic [CW-1:0] run_q, run_nxt;
  logic          same_bit;

  assign same_bit = have_prev && (bit_in == prev_bit);

  always_comb begin
    run_nxt = run_q;
    if (bit_valid)
      run_nxt = CW'(next_run(32'(run_q), same_bit, RUN_LEN));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= '0;
      prev_bit  <= 1'b0;
      have_prev <= 1'b0;
      mute_req  <= 1'b0;
    end else begin
      run_q    <= run_nxt;
      mute_req <= enable && (32'(run_nxt) >= RUN_LEN);
      if (bit_valid) begin
        prev_bit  <= bit_in;
        have_prev <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dsd_window_detector.sv
module dsd_window_detector #(
  parameter int unsigned WIN_LEN   = 28,
  parameter int unsigned DOM_LIMIT = 24,
  localparam int unsigned CW = $clog2(WIN_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_valid,
  input  logic enable,
  output logic atten_nxt,
  output logic atten_req,
  output logic window_full
);
  import dsd_mon_pkg::*;

  logic [WIN_LEN-1:0] hist_q;
  logic [CW-1:0]      ones_q, ones_nxt;
  logic [CW-1:0]      fill_q, fill_nxt;
  logic               leaving;

  assign window_full = (32'(fill_q) == WIN_LEN);
  assign leaving     = window_full && hist_q[WIN_LEN-1];

  always_comb begin
    ones_nxt = ones_q;
    fill_nxt = fill_q;
    if (bit_valid) begin
      ones_nxt = ones_q + CW'(bit_in) - CW'(leaving);
      if (!window_full) fill_nxt = fill_q + CW'(1);
    end
  end

  assign atten_nxt = enable && (32'(fill_nxt) == WIN_LEN) &&
                     is_dominant(32'(ones_nxt), WIN_LEN, DOM_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q    <= '0;
      ones_q    <= '0;
      fill_q    <= '0;
      atten_req <= 1'b0;
    end else begin
      if (bit_valid) hist_q <= {hist_q[WIN_LEN-2:0], bit_in};
      ones_q    <= ones_nxt;
      fill_q    <= fill_nxt;
      atten_req <= atten_nxt;
    end
  end

endmodule

// File: rtl/dsd_output_gate.sv
module dsd_output_gate (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_valid,
  input  logic gate_en,
  output logic dout,
  output logic dout_valid
);
  logic idle_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout       <= 1'b0;
      dout_valid <= 1'b0;
      idle_phase <= 1'b0;
    end else begin
      dout_valid <= bit_valid;
      if (bit_valid) begin
        dout       <= gate_en ? idle_phase : bit_in;
        idle_phase <= ~idle_phase;
      end
    end
  end

endmodule

// File: rtl/dsd_stream_monitor.sv
module dsd_stream_monitor #(
  parameter int unsigned RUN_LEN   = 28,
  parameter int unsigned WIN_LEN   = 28,
  parameter int unsigned DOM_LIMIT = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_valid,
  input  logic cfg_load,
  input  logic cfg_static_en,
  input  logic cfg_invalid_en,
  input  logic cfg_bypass,
  input  logic cfg_pm_en,
  input  logic cfg_pm_rate64,
  output logic mute_req,
  output logic atten_req,
  output logic dout,
  output logic dout_valid,
  output logic pm_sclk_64x
);
  import dsd_mon_pkg::*;

  mon_cfg_t cfg_q;
  logic     prev_bit, have_prev;
  logic     atten_nxt, window_full;
  logic     gate_now;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= CFG_DEFAULT;
    else if (cfg_load)
      cfg_q <= '{static_en: cfg_static_en, invalid_en: cfg_invalid_en,
                 bypass: cfg_bypass, pm_en: cfg_pm_en, pm_rate64: cfg_pm_rate64};
  end

  dsd_run_detector #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
    .enable(cfg_q.static_en), .mute_req(mute_req),
    .prev_bit(prev_bit), .have_prev(have_prev)
  );

  dsd_window_detector #(.WIN_LEN(WIN_LEN), .DOM_LIMIT(DOM_LIMIT)) u_win (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
    .enable(cfg_q.invalid_en), .atten_nxt(atten_nxt),
    .atten_req(atten_req), .window_full(window_full)
  );

  assign gate_now = atten_nxt && !cfg_q.bypass;

  dsd_output_gate u_gate (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
    .gate_en(gate_now), .dout(dout), .dout_valid(dout_valid)
  );

  assign pm_sclk_64x = cfg_q.pm_en && cfg_q.pm_rate64;

endmodule

// File: rtl/dsd_stream_monitor_chk.sv
module dsd_stream_monitor_chk (
  input logic clk,
  input logic rst,
  input logic bit_in,
  input logic bit_valid,
  input logic static_en,
  input logic bypass,
  input logic prev_bit,
  input logic have_prev,
  input logic window_full,
  input logic mute_req,
  input logic atten_req,
  input logic dout,
  input logic dout_valid
);

  assert_mute_needs_history_R1: assert property (@(posedge clk) disable iff (rst)
    mute_req |-> have_prev);

  assert_mute_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (mute_req && bit_valid && have_prev && (bit_in != prev_bit)) |=> !mute_req);

  assert_static_off_R3: assert property (@(posedge clk) disable iff (rst)
    !static_en |=> !mute_req);

  assert_atten_after_fill_R4: assert property (@(posedge clk) disable iff (rst)
    atten_req |-> window_full);

  assert_strobe_follows_R6: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> dout_valid);

  assert_bypass_clean_R7: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && bypass) |=> (dout == $past(bit_in)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> ($stable(dout) && !dout_valid));

endmodule

bind dsd_stream_monitor dsd_stream_monitor_chk u_chk (
  .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
  .static_en(cfg_q.static_en), .bypass(cfg_q.bypass),
  .prev_bit(prev_bit), .have_prev(have_prev), .window_full(window_full),
  .mute_req(mute_req), .atten_req(atten_req),
  .dout(dout), .dout_valid(dout_valid)
);

// File: tb/dsd_stream_monitor_test.sv
module dsd_stream_monitor_test;

  logic clk = 1'b0;
  logic rst, bit_in, bit_valid, cfg_load;
  logic cfg_static_en, cfg_invalid_en, cfg_bypass, cfg_pm_en, cfg_pm_rate64;
  logic mute_req, atten_req, dout, dout_valid, pm_sclk_64x;

  always #2 clk = ~clk;

  dsd_stream_monitor uut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
    .cfg_load(cfg_load), .cfg_static_en(cfg_static_en),
    .cfg_invalid_en(cfg_invalid_en), .cfg_bypass(cfg_bypass),
    .cfg_pm_en(cfg_pm_en), .cfg_pm_rate64(cfg_pm_rate64),
    .mute_req(mute_req), .atten_req(atten_req), .dout(dout),
    .dout_valid(dout_valid), .pm_sclk_64x(pm_sclk_64x)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // reference model state
  bit mq[$];
  int m_count;
  bit m_static, m_inv, m_byp, m_pmen, m_pm64;
  bit m_mute, m_atten, m_dout, m_dv, m_idle;

  function automatic int m_ones();
    int c = 0;
    int sz = mq.size();
    int lo = (sz > 28) ? sz - 28 : 0;
    for (int i = lo; i < sz; i++) c += int'(mq[i]);
    return c;
  endfunction

  function automatic int m_run();
    int sz = mq.size();
    int c = 1;
    if (sz == 0) return 0;
    for (int i = sz - 2; i >= 0 && c < 28; i--) begin
      if (mq[i] == mq[sz-1]) c++;
      else break;
    end
    return c;
  endfunction

  function automatic bit m_atten_calc();
    int o = m_ones();
    return m_inv && (m_count >= 28) && ((o >= 25) || (o <= 3));
  endfunction

  task automatic check1(string req, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string req);
    check1(req, "mute_req", mute_req, m_mute);
    check1(req, "atten_req", atten_req, m_atten);
    check1(req, "dout", dout, m_dout);
    check1(req, "dout_valid", dout_valid, m_dv);
    check1(req, "pm_sclk_64x", pm_sclk_64x, m_pmen & m_pm64);
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_valid = 1'b0; bit_in = 1'b0; cfg_load = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    mq.delete(); m_count = 0;
    m_static = 1; m_inv = 0; m_byp = 0; m_pmen = 0; m_pm64 = 0;
    m_mute = 0; m_atten = 0; m_dout = 0; m_dv = 0; m_idle = 0;
    compare_all("R10");
  endtask

  task automatic send(bit b, string req);
    bit_in = b; bit_valid = 1'b1;
    mq.push_back(b);
    if (mq.size() > 64) void'(mq.pop_front());
    if (m_count < 1000) m_count++;
    m_atten = m_atten_calc();
    m_mute  = m_static && (m_run() >= 28);
    m_dout  = (m_atten && !m_byp) ? m_idle : b;
    m_idle  = ~m_idle;
    m_dv    = 1;
    @(posedge clk); @(negedge clk);
    bit_valid = 1'b0;
    compare_all(req);
  endtask

  task automatic idle_clk(string req);
    bit_valid = 1'b0;
    m_mute  = m_static && (m_run() >= 28);
    m_atten = m_atten_calc();
    m_dv    = 0;
    @(posedge clk); @(negedge clk);
    compare_all(req);
  endtask

  // R9: fields load on the strobe; inverted values afterwards must be ignored
  task automatic set_cfg(bit s, bit i, bit b, bit pe, bit p64);
    cfg_static_en = s; cfg_invalid_en = i; cfg_bypass = b;
    cfg_pm_en = pe; cfg_pm_rate64 = p64; cfg_load = 1'b1; bit_valid = 1'b0;
    m_mute  = m_static && (m_run() >= 28);
    m_atten = m_atten_calc();
    m_dv    = 0;
    @(posedge clk); @(negedge clk);
    cfg_load = 1'b0;
    cfg_static_en = ~s; cfg_invalid_en = ~i; cfg_bypass = ~b;
    cfg_pm_en = ~pe; cfg_pm_rate64 = ~p64;
    m_static = s; m_inv = i; m_byp = b; m_pmen = pe; m_pm64 = p64;
    compare_all("R9");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    cfg_static_en = 0; cfg_invalid_en = 1; cfg_bypass = 1; cfg_pm_en = 1; cfg_pm_rate64 = 1;
    do_reset();

    // R1, R5 defaults with a long zero run; R2 on the change
    for (int i = 0; i < 31; i++) send(1'b0, "R1_R5");
    send(1'b1, "R2");
    send(1'b1, "R2");

    // run-length sweep around the threshold
    for (int len = 25; len <= 30; len++) begin
      do_reset();
      for (int i = 0; i < len; i++) send(1'b1, "R1");
      send(1'b0, "R2");
      idle_clk("R11");
    end

    // R3: disable, long run, re-enable mid-run
    do_reset();
    set_cfg(0, 0, 0, 0, 0);
    for (int i = 0; i < 35; i++) send(1'b1, "R3");
    set_cfg(1, 0, 0, 0, 0);
    idle_clk("R3");
    set_cfg(0, 0, 0, 0, 0);
    idle_clk("R3");

    // R4, R6: dominance sweep with evenly spread ones
    for (int k = 0; k <= 28; k++) begin
      do_reset();
      set_cfg(1, 1, 0, 0, 0);
      for (int i = 0; i < 56; i++) send(((i * k) % 28) < k, "R4_R6");
    end

    // R7: bypass keeps data clean while attenuate is reported
    do_reset();
    set_cfg(1, 1, 1, 0, 0);
    for (int i = 0; i < 36; i++) send(1'b0, "R7");
    for (int i = 0; i < 10; i++) send(i[0], "R7");

    // R10: mid-stream reset restarts the fill count
    do_reset();
    set_cfg(1, 1, 0, 0, 0);
    for (int i = 0; i < 30; i++) send(1'b1, "R10");
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    mq.delete(); m_count = 0;
    m_static = 1; m_inv = 0; m_byp = 0; m_pmen = 0; m_pm64 = 0;
    m_mute = 0; m_atten = 0; m_dout = 0; m_dv = 0; m_idle = 0;
    compare_all("R10");
    set_cfg(1, 1, 0, 0, 0);
    for (int i = 0; i < 29; i++) send(1'b1, "R10");

    // R11: pseudo-random stream with valid gaps, both detectors on
    do_reset();
    set_cfg(1, 1, 0, 0, 0);
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:1] == 3'b000) idle_clk("R11");
      else if (i > 300) send(lfsr[0] | lfsr[5] | lfsr[7], "R4_R11");
      else send(lfsr[0], "R11");
      if (i == 450) set_cfg(1, 1, 1, 0, 0);
    end

    // R8: phase-modulation clock select combinations
    do_reset();
    for (int c = 0; c < 4; c++) begin
      set_cfg(1, 0, 0, c[1], c[0]);
      idle_clk("R8");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule